// File: doc/BRIEF.md
# Set/Clear GPIO Port Controller

This block is a 32-pin general-purpose I/O port sitting behind a small memory-mapped register bus. Firmware never writes the direction or output vectors as whole words. It changes them only through strobe registers, where a one in the write data selects a pin and a zero leaves that pin alone. Writing to the output-set strobe or to the output-clear strobe updates the pin's output level. As a side effect, the same write also turns that pin into a driven output. A separate strobe returns selected pins to input mode.

Pin levels reach the status register through a two-flop synchronizer. The status register reads as zero after reset until firmware has written, with any data, to the status offset at least once. From then on sampling stays enabled until the next reset. Read data is combinational from the current address. Writes take effect at the clock edge on which the write enable is sampled high.

Top module: `gpio_sc_port`

## Requirements
- R1: Synchronous active-high reset clears every output-enable bit and every output-value bit, and disarms input sampling, so reads at 0x100, 0x108 and 0x110 return zero.
- R2: A write to offset 0x100 clears the output-enable bit of each pin whose data bit is one (the pin becomes an input). A read at 0x100 returns the output-enable vector, bit n for pin n.
- R3: A write to offset 0x108 sets the output-value bit of each pin whose data bit is one. A read at 0x108 returns the output-value vector.
- R4: A write to offset 0x10C clears the output-value bit of each pin whose data bit is one. A read at 0x10C returns zero.
- R5: A write to 0x108 or to 0x10C also sets the output-enable bit of every pin it selects.
- R6: Pins whose data bit is zero in a write to 0x100, 0x108 or 0x10C keep both their output-enable and output-value bits.
- R7: Once sampling is armed, a read at 0x110 returns the pin input vector. A change on a pin input becomes visible after exactly two rising clock edges, and is not visible after one.
- R8: Reads at 0x110 return zero until a write of any data value reaches 0x110. After that, sampling stays armed until reset.
- R9: Reads at any offset other than 0x100, 0x108, 0x10C and 0x110 return zero. Writes to such offsets change neither the output-enable nor the output-value vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_oe | output | 32 | Per-pin output enable, 1 = pin driven |
| pad_out | output | 32 | Per-pin output value |
| pad_in | input | 32 | Per-pin level seen at the pad, asynchronous |

## Verification
The assertions assume the following about the inputs. Each cycle in which bus_we is high is a separate write. bus_addr, bus_we and bus_wdata are settled at the rising edge, and reset is held from time zero. The pin inputs are assumed asynchronous, so no property ties the status value to a past pin value. The bench drives every bus input on the falling edge and changes pad_in only in directed sections. After such a change it waits enough edges before it compares the status register against its model. Random writes and reads mix the four mapped offsets with unmapped offsets.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_DIR_CLR  = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_VAL_SET  = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_VAL_CLR  = 12'h10C;
    localparam logic [ADDR_W-1:0] OFS_PIN_STAT = 12'h110;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_DIR,
        REG_VSET,
        REG_VCLR,
        REG_STAT
    } reg_sel_e;

    typedef struct packed {
        logic dir_clr;
        logic val_set;
        logic val_clr;
        logic arm;
    } wr_cmd_t;

    function automatic reg_sel_e map_offset(input logic [ADDR_W-1:0] ofs);
        reg_sel_e r;
        case (ofs)
            OFS_DIR_CLR:  r = REG_DIR;
            OFS_VAL_SET:  r = REG_VSET;
            OFS_VAL_CLR:  r = REG_VCLR;
            OFS_PIN_STAT: r = REG_STAT;
            default:      r = REG_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
    import gpio_sc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output reg_sel_e          sel,
    output wr_cmd_t           cmd
);

    always_comb begin
        sel = map_offset(addr);
        cmd = '0;
        if (we) begin
            case (sel)
                REG_DIR:  cmd.dir_clr = 1'b1;
                REG_VSET: cmd.val_set = 1'b1;
                REG_VCLR: cmd.val_clr = 1'b1;
                REG_STAT: cmd.arm     = 1'b1;
                default:  cmd         = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_sc_drive.sv
module gpio_sc_drive
    import gpio_sc_pkg::*;
#(
    parameter int PIN_CNT = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_cmd_t            cmd,
    input  logic [PIN_CNT-1:0] mask,
    output logic [PIN_CNT-1:0] oe_q,
    output logic [PIN_CNT-1:0] val_q
);

    logic touch_val;
    assign touch_val = cmd.val_set | cmd.val_clr;

    for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
        logic oe_r;
        logic val_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                oe_r  <= 1'b0;
                val_r <= 1'b0;
            end else if (mask[i]) begin
                if (touch_val) begin
                    oe_r <= 1'b1;
                end else if (cmd.dir_clr) begin
                    oe_r <= 1'b0;
                end
                if (cmd.val_set) begin
                    val_r <= 1'b1;
                end else if (cmd.val_clr) begin
                    val_r <= 1'b0;
                end
            end
        end

        assign oe_q[i]  = oe_r;
        assign val_q[i] = val_r;
    end

endmodule

// File: rtl/gpio_sc_sample.sv
module gpio_sc_sample #(
    parameter int PIN_CNT     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm_wr,
    input  logic [PIN_CNT-1:0] pin_in,
    output logic [PIN_CNT-1:0] level,
    output logic               armed
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0][PIN_CNT-1:0] chain;
    logic                                armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= pin_in;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (arm_wr) begin
            armed_q <= 1'b1;
        end
    end

    assign armed = armed_q;
    assign level = armed_q ? chain[LAST] : '0;

endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
    import gpio_sc_pkg::*;
#(
    parameter int PIN_CNT     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [PIN_CNT-1:0] bus_wdata,
    output logic [PIN_CNT-1:0] bus_rdata,
    output logic [PIN_CNT-1:0] pad_oe,
    output logic [PIN_CNT-1:0] pad_out,
    input  logic [PIN_CNT-1:0] pad_in
);

    reg_sel_e           sel;
    wr_cmd_t            cmd;
    logic [PIN_CNT-1:0] pin_level;
    logic               sample_armed;

    gpio_sc_decode u_decode (
        .addr (bus_addr),
        .we   (bus_we),
        .sel  (sel),
        .cmd  (cmd)
    );

    gpio_sc_drive #(
        .PIN_CNT (PIN_CNT)
    ) u_drive (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .mask  (bus_wdata),
        .oe_q  (pad_oe),
        .val_q (pad_out)
    );

    gpio_sc_sample #(
        .PIN_CNT     (PIN_CNT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sample (
        .clk    (clk),
        .rst    (rst),
        .arm_wr (cmd.arm),
        .pin_in (pad_in),
        .level  (pin_level),
        .armed  (sample_armed)
    );

    always_comb begin
        case (sel)
            REG_DIR:  bus_rdata = pad_oe;
            REG_VSET: bus_rdata = pad_out;
            REG_STAT: bus_rdata = pin_level;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_sc_chk.sv
module gpio_sc_chk
    import gpio_sc_pkg::*;
#(
    parameter int PIN_CNT = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [PIN_CNT-1:0] bus_wdata,
    input logic [PIN_CNT-1:0] bus_rdata,
    input logic [PIN_CNT-1:0] pad_oe,
    input logic [PIN_CNT-1:0] pad_out,
    input logic               sample_armed
);

    logic unmapped;
    assign unmapped = (bus_addr != OFS_DIR_CLR) && (bus_addr != OFS_VAL_SET) &&
                      (bus_addr != OFS_VAL_CLR) && (bus_addr != OFS_PIN_STAT);

    // R2
    dir_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_DIR_CLR) |=> ((pad_oe & $past(bus_wdata)) == '0));

    // R3 R5
    val_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_VAL_SET) |=>
            (((pad_out & $past(bus_wdata)) == $past(bus_wdata)) &&
             ((pad_oe & $past(bus_wdata)) == $past(bus_wdata))));

    // R4 R5
    val_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_VAL_CLR) |=>
            (((pad_out & $past(bus_wdata)) == '0) &&
             ((pad_oe & $past(bus_wdata)) == $past(bus_wdata))));

    // R6
    zero_bits_keep_chk: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> (((pad_out ^ $past(pad_out)) & ~$past(bus_wdata)) == '0) &&
                   (((pad_oe ^ $past(pad_oe)) & ~$past(bus_wdata)) == '0));

    // R8
    arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        sample_armed |=> sample_armed);

    // R8
    disarmed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!sample_armed && bus_addr == OFS_PIN_STAT) |-> (bus_rdata == '0));

    // R9
    unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && unmapped) |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

bind gpio_sc_port gpio_sc_chk #(
    .PIN_CNT (PIN_CNT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pad_oe       (pad_oe),
    .pad_out      (pad_out),
    .sample_armed (sample_armed)
);

// File: tb/gpio_sc_port_tb.sv
module gpio_sc_port_tb;

    localparam logic [11:0] A_DIR  = 12'h100;
    localparam logic [11:0] A_VSET = 12'h108;
    localparam logic [11:0] A_VCLR = 12'h10C;
    localparam logic [11:0] A_STAT = 12'h110;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;
    logic [31:0] pad_in = '0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [31:0] m_oe = '0;
    logic [31:0] m_out = '0;
    bit          m_armed = 1'b0;

    always #2 clk = ~clk;

    gpio_sc_port u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_in    (pad_in)
    );

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
        case (a)
            A_DIR:  m_oe = m_oe & ~d;
            A_VSET: begin m_out = m_out | d;  m_oe = m_oe | d; end
            A_VCLR: begin m_out = m_out & ~d; m_oe = m_oe | d; end
            A_STAT: m_armed = 1'b1;
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            A_DIR:   return m_oe;
            A_VSET:  return m_out;
            A_STAT:  return m_armed ? pad_in : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_we = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic read_check(input string req, input logic [11:0] a);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, model_read(a));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        m_oe = '0; m_out = '0; m_armed = 1'b0;
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        read_check("R1 dir read", A_DIR);
        read_check("R1 value read", A_VSET);
        read_check("R1 status read", A_STAT);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog all-requirements act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h1357_2468));

        pad_in = 32'hFFFF_FFFF;
        do_reset();
        repeat (3) @(negedge clk);
        read_check("R8 status before arm", A_STAT);

        bus_write(A_VSET, 32'h0000_00F0);
        read_check("R3 set read", A_VSET);
        read_check("R5 set makes output", A_DIR);

        bus_write(A_VCLR, 32'h0000_0030);
        read_check("R4 clear read", A_VSET);
        bus_write(A_VCLR, 32'h0000_0F00);
        read_check("R5 clear makes output", A_DIR);
        check("R6 value kept", pad_out, 32'h0000_00C0);
        read_check("R4 clear offset reads zero", A_VCLR);

        bus_write(A_DIR, 32'h0000_00F0);
        check("R2 dir cleared", pad_oe, 32'h0000_0F00);
        check("R6 value kept on dir write", pad_out, 32'h0000_00C0);
        read_check("R2 dir read", A_DIR);

        bus_write(A_STAT, 32'h0);
        read_check("R8 armed by zero write", A_STAT);

        // R7 latency: change at falling edge, one rising edge not enough
        @(negedge clk);
        pad_in = 32'hA5A5_0F0F;
        @(negedge clk);
        bus_read(A_STAT, d);
        check("R7 one edge", d, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_read(A_STAT, d);
        check("R7 two edges", d, 32'hA5A5_0F0F);

        bus_write(12'h104, 32'hFFFF_FFFF);
        check("R9 unmapped write oe", pad_oe, m_oe);
        check("R9 unmapped write out", pad_out, m_out);
        read_check("R9 unmapped read", 12'h104);

        for (int k = 0; k < 600; k++) begin
            int op;
            logic [11:0] a;
            logic [31:0] dd;
            op = $urandom % 6;
            dd = $urandom;
            if (($urandom % 4) == 0) dd = dd & $urandom & $urandom;
            case (op)
                0: a = A_DIR;
                1: a = A_VSET;
                2: a = A_VCLR;
                3: a = A_STAT;
                default: begin
                    a = 12'($urandom) & 12'hFFC;
                    if (a == A_DIR || a == A_VSET || a == A_VCLR || a == A_STAT)
                        a = a ^ 12'h800;
                end
            endcase
            if ($urandom % 3 != 0) begin
                bus_write(a, dd);
                check("R2 R3 R4 R5 R6 random oe", pad_oe, m_oe);
                check("R3 R4 R6 R9 random out", pad_out, m_out);
            end else begin
                @(negedge clk);
                read_check("R2 R3 R4 R7 R8 R9 random read", a);
            end
        end
        read_check("R8 still armed", A_STAT);

        do_reset();
        repeat (3) @(negedge clk);
        read_check("R1 R8 disarmed after reset", A_STAT);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule